// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins, placed behind a plain 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data. Software programs each pin through a set of configuration registers. A two-bit direction mode and a two-bit pull setting sit at fixed positions per pin, and further registers hold output type, output speed and two alternate-function words. The port drives sixteen output lines and samples sixteen input lines.

The output level register can be written whole, or changed atomically through a set/clear register in which a set request beats a clear request for the same pin. A pin line follows a change of its output bit only while its mode field is non-zero. An input level is captured into the input register only when the pin is in input mode with a non-zero pull setting. A parameter gives the port's identity, and the identity selects the reset values of the mode, pull and speed registers.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Configuration registers are read back at these byte offsets: mode 0x00, output type 0x04, output speed 0x08, pull 0x0C, alternate function low 0x20, alternate function high 0x24. All are 32 bits wide, except output type, which keeps bits 15:0 and reads bits 31:16 as zero.
- R2: Reset values depend on the identity parameter. Identity 0 resets to mode 0xA8000000, pull 0x64000000, speed 0. Identity 1 resets to mode 0x00000280, pull 0x00000100, speed 0x000000C0. Any other identity resets all three to zero. Every other register and every output line resets to zero.
- R3: A write to offset 0x14 loads the output level register from write-data bits 15:0. Bits 31:16 of that register read as zero.
- R4: A write to offset 0x18 sets output bit i when write-data bit i is 1 and clears it when write-data bit 16+i is 1. When both are 1, the bit ends up set. Bits with neither request keep their value.
- R5: Offsets 0x18 and 0x1C always read as zero. A write to the input register at offset 0x10 has no effect.
- R6: Pin i uses mode bits [2i+1:2i]. When output bit i changes and that field is non-zero, pin_out[i] takes the new level on the same clock edge that updates the register. While the field is 00, pin_out[i] holds its level. Setting a field non-zero does not by itself copy a bit that has not changed.
- R7: Each input passes through two synchronizing flops. A change of the synchronized level of pin i updates input bit i (offset 0x10) only when mode field i is 00 and pull field i (pull bits [2i+1:2i]) is non-zero. A change in any other configuration is discarded.
- R8: Read data appears on bus_rdata one cycle after bus_re. In any cycle that follows no read, bus_rdata is zero.
- R9: An access that is not a multiple of four, or that lies above 0x24, reads as zero, writes nothing, and raises bus_err for exactly one cycle, aligned with the read data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an undecoded access |
| pin_in | input | 16 | Input pin levels, asynchronous |
| pin_out | output | 16 | Output pin levels |

## Verification
The hardest case to reach is the one where the output bit and the pin line disagree. Software must first change an output bit while its mode field is 00, and only then make the pin an output. A correct port keeps the old line level, while a port that follows the register level would copy the bit. The stimulus gets there by leaving pins 2 and 3 in mode 00 during the set/clear sequence and then switching them to output mode. The line must stay put until a later write changes those bits again. The same pattern is used for the input side: a pin's level moves while it is configured as an output, and the bench checks that the input register keeps the earlier capture.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PIN_CNT  = 16;
    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 2;
    localparam int HALF_W   = DATA_W / 2;
    localparam int IDX_W    = 4;

    // word index of each register (byte offset / 4)
    typedef enum logic [IDX_W-1:0] {
        RI_MODE  = 4'd0,
        RI_OTYPE = 4'd1,
        RI_SPEED = 4'd2,
        RI_PULL  = 4'd3,
        RI_IDR   = 4'd4,
        RI_ODR   = 4'd5,
        RI_BSR   = 4'd6,
        RI_LOCK  = 4'd7,
        RI_AFL   = 4'd8,
        RI_AFH   = 4'd9
    } reg_idx_e;

    localparam int LAST_IDX = 9;

    typedef struct packed {
        logic [DATA_W-1:0]  mode;
        logic [PIN_CNT-1:0] otype;
        logic [DATA_W-1:0]  speed;
        logic [DATA_W-1:0]  pull;
        logic [DATA_W-1:0]  afl;
        logic [DATA_W-1:0]  afh;
        logic [PIN_CNT-1:0] idr;
        logic [PIN_CNT-1:0] odr;
        logic [PIN_CNT-1:0] pin;
        logic [DATA_W-1:0]  rdata;
        logic               err;
    } port_state_t;

    function automatic logic [DATA_W-1:0] reset_mode(input int id);
        case (id)
            0:       return 32'hA800_0000;
            1:       return 32'h0000_0280;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reset_pull(input int id);
        case (id)
            0:       return 32'h6400_0000;
            1:       return 32'h0000_0100;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reset_speed(input int id);
        case (id)
            1:       return 32'h0000_00C0;
            default: return '0;
        endcase
    endfunction

    function automatic port_state_t reset_state(input int id);
        port_state_t s;
        s       = '0;
        s.mode  = reset_mode(id);
        s.pull  = reset_pull(id);
        s.speed = reset_speed(id);
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_idx_e          idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        hit     = aligned && (word <= WORD_W'(LAST_IDX));
        idx     = reg_idx_e'(word[IDX_W-1:0]);
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = raw;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl = sy_q.s2;
    assign chg = sy_q.s2 ^ sy_q.prev;
endmodule

// File: rtl/gpio_odr_merge.sv
module gpio_odr_merge #(
    parameter int W      = 16,
    parameter int DATA_W = 32
) (
    input  logic [W-1:0]      odr_q,
    input  logic              wr_direct,
    input  logic              wr_setclr,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      odr_d
);
    localparam int HALF = DATA_W / 2;

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    always_comb begin
        set_v = wdata[W-1:0];
        clr_v = wdata[HALF+W-1:HALF];
        odr_d = odr_q;
        if (wr_direct)
            odr_d = wdata[W-1:0];
        else if (wr_setclr)
            odr_d = (odr_q & ~clr_v) | set_v;   // set applied last: set wins
    end
endmodule

// File: rtl/gpio_pin_gate.sv
module gpio_pin_gate #(
    parameter int W       = 16,
    parameter int FIELD_W = 2
) (
    input  logic [W-1:0]         odr_q,
    input  logic [W-1:0]         odr_d,
    input  logic [W*FIELD_W-1:0] mode_q,
    input  logic [W-1:0]         pin_q,
    output logic [W-1:0]         pin_d
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic moved;
        logic driving;
        assign moved    = odr_q[i] ^ odr_d[i];
        assign driving  = |mode_q[i*FIELD_W +: FIELD_W];
        assign pin_d[i] = (moved && driving) ? odr_d[i] : pin_q[i];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PORT_ID = 0,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [15:0]       pin_in,
    output logic [15:0]       pin_out
);
    localparam port_state_t RST_STATE = reset_state(PORT_ID);
    localparam int          MODE_W    = PIN_CNT * FIELD_W;

    port_state_t st_d, st_q;

    logic               acc_hit;
    reg_idx_e           acc_idx;
    logic               wr_ok;
    logic               rd_ok;
    logic               wr_direct;
    logic               wr_setclr;
    logic [PIN_CNT-1:0] odr_nxt;
    logic [PIN_CNT-1:0] pin_nxt;
    logic [PIN_CNT-1:0] in_lvl;
    logic [PIN_CNT-1:0] in_chg;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (acc_hit),
        .idx  (acc_idx)
    );

    gpio_in_sync #(.W(PIN_CNT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .lvl   (in_lvl),
        .chg   (in_chg)
    );

    assign wr_ok     = bus_we && acc_hit;
    assign rd_ok     = bus_re && acc_hit;
    assign wr_direct = wr_ok && (acc_idx == RI_ODR);
    assign wr_setclr = wr_ok && (acc_idx == RI_BSR);

    gpio_odr_merge #(.W(PIN_CNT), .DATA_W(DATA_W)) u_merge (
        .odr_q     (st_q.odr),
        .wr_direct (wr_direct),
        .wr_setclr (wr_setclr),
        .wdata     (bus_wdata),
        .odr_d     (odr_nxt)
    );

    gpio_pin_gate #(.W(PIN_CNT), .FIELD_W(FIELD_W)) u_gate (
        .odr_q  (st_q.odr),
        .odr_d  (odr_nxt),
        .mode_q (st_q.mode[MODE_W-1:0]),
        .pin_q  (st_q.pin),
        .pin_d  (pin_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = 1'b0;

        // configuration writes
        if (wr_ok) begin
            case (acc_idx)
                RI_MODE:  st_d.mode  = bus_wdata;
                RI_OTYPE: st_d.otype = bus_wdata[PIN_CNT-1:0];
                RI_SPEED: st_d.speed = bus_wdata;
                RI_PULL:  st_d.pull  = bus_wdata;
                RI_AFL:   st_d.afl   = bus_wdata;
                RI_AFH:   st_d.afh   = bus_wdata;
                default:  ;
            endcase
        end

        // output level and pin lines
        st_d.odr = odr_nxt;
        st_d.pin = pin_nxt;

        // input capture, qualified per pin
        for (int i = 0; i < PIN_CNT; i++) begin
            if (in_chg[i]
                && (st_q.mode[i*FIELD_W +: FIELD_W] == 2'b00)
                && (st_q.pull[i*FIELD_W +: FIELD_W] != 2'b00))
                st_d.idr[i] = in_lvl[i];
        end

        // registered read path
        if (rd_ok) begin
            case (acc_idx)
                RI_MODE:  st_d.rdata = st_q.mode;
                RI_OTYPE: st_d.rdata = {{HALF_W{1'b0}}, st_q.otype};
                RI_SPEED: st_d.rdata = st_q.speed;
                RI_PULL:  st_d.rdata = st_q.pull;
                RI_IDR:   st_d.rdata = {{HALF_W{1'b0}}, st_q.idr};
                RI_ODR:   st_d.rdata = {{HALF_W{1'b0}}, st_q.odr};
                RI_AFL:   st_d.rdata = st_q.afl;
                RI_AFH:   st_d.rdata = st_q.afh;
                default:  st_d.rdata = '0;
            endcase
        end

        st_d.err = (bus_re || bus_we) && !acc_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
    assign pin_out   = st_q.pin;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [15:0]       pin_out,
    input logic [31:0]       mode_q,
    input logic [31:0]       pull_q,
    input logic [15:0]       odr_q,
    input logic [15:0]       idr_q
);
    localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(8'h18);
    localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] A_TOP    = ADDR_W'(8'h24);

    logic decoded;
    assign decoded = (bus_addr[1:0] == 2'b00) && (bus_addr <= A_TOP);

    // R4
    setclr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SETCLR)
        |=> ((odr_q & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0])));

    // R4
    setclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SETCLR)
        |=> ((odr_q & $past(bus_wdata[31:16] & ~bus_wdata[15:0])) == 16'h0));

    // R5
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr == A_SETCLR || bus_addr == A_LOCK))
        |=> (bus_rdata == 32'h0));

    // R8
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == 32'h0));

    // R9
    bad_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_re || bus_we) && !decoded) |=> (bus_err && bus_rdata == 32'h0));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_re || bus_we) && decoded) |=> !bus_err);

    for (genvar i = 0; i < 16; i++) begin : g_pin_chk
        // R6
        pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b00) |=> $stable(pin_out[i]));

        // R7
        idr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !((mode_q[2*i +: 2] == 2'b00) && (pull_q[2*i +: 2] != 2'b00))
            |=> $stable(idr_q[i]));
    end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .pin_out   (pin_out),
    .mode_q    (st_q.mode),
    .pull_q    (st_q.pull),
    .odr_q     (st_q.odr),
    .idr_q     (st_q.idr)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [15:0] pin_in = '0;

    logic [31:0] rd_a, rd_b, rd_c;
    logic        err_a, err_b, err_c;
    logic [15:0] po_a, po_b, po_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctrl #(.PORT_ID(0), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_a),
        .bus_err(err_a), .pin_in(pin_in), .pin_out(po_a));

    gpio_port_ctrl #(.PORT_ID(1), .ADDR_W(8)) uut_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_b),
        .bus_err(err_b), .pin_in(pin_in), .pin_out(po_b));

    gpio_port_ctrl #(.PORT_ID(2), .ADDR_W(8)) uut_c (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_c),
        .bus_err(err_c), .pin_in(pin_in), .pin_out(po_c));

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h00, 32'h0000_0005, 32'h0, 1'b0, 4'd1},  // R1 mode: pins 0,1 output
        '{1'b0, 8'h00, 32'h0, 32'h0000_0005, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h04, 32'hFFFF_00F0, 32'h0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h04, 32'h0, 32'h0000_00F0, 1'b0, 4'd1},  // R1 upper half zero
        '{1'b1, 8'h08, 32'hDEAD_BEEF, 32'h0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h08, 32'h0, 32'hDEAD_BEEF, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h0C, 32'h0000_0100, 32'h0, 1'b0, 4'd1},  // R1 pin 4 pull
        '{1'b0, 8'h0C, 32'h0, 32'h0000_0100, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h20, 32'h1234_5678, 32'h0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h20, 32'h0, 32'h1234_5678, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h24, 32'h9ABC_DEF0, 32'h0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h24, 32'h0, 32'h9ABC_DEF0, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h14, 32'hABCD_000F, 32'h0, 1'b0, 4'd3},  // R3
        '{1'b0, 8'h14, 32'h0, 32'h0000_000F, 1'b0, 4'd3},  // R3
        '{1'b1, 8'h18, 32'h0003_0030, 32'h0, 1'b0, 4'd4},  // R4 clr 0,1 set 4,5
        '{1'b0, 8'h14, 32'h0, 32'h0000_003C, 1'b0, 4'd4},  // R4
        '{1'b1, 8'h18, 32'h0100_0100, 32'h0, 1'b0, 4'd4},  // R4 both on bit 8
        '{1'b0, 8'h14, 32'h0, 32'h0000_013C, 1'b0, 4'd4},  // R4 set wins
        '{1'b0, 8'h18, 32'h0, 32'h0, 1'b0, 4'd5},          // R5
        '{1'b0, 8'h1C, 32'h0, 32'h0, 1'b0, 4'd5},          // R5
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd5},  // R5
        '{1'b0, 8'h10, 32'h0, 32'h0, 1'b0, 4'd5},          // R5 write ignored
        '{1'b0, 8'h28, 32'h0, 32'h0, 1'b1, 4'd9},          // R9 above range
        '{1'b1, 8'h2C, 32'h1111_1111, 32'h0, 1'b1, 4'd9},  // R9
        '{1'b1, 8'h01, 32'h7777_7777, 32'h0, 1'b1, 4'd9},  // R9 misaligned
        '{1'b0, 8'h00, 32'h0, 32'h0000_0005, 1'b0, 4'd9}   // R9 mode untouched
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge
    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = wr;
        bus_re    = !wr;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_re    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset values for three identities
        access(1'b0, 8'h00, 0);
        chk("R2 mode A", rd_a, 32'hA800_0000);
        chk("R2 mode B", rd_b, 32'h0000_0280);
        chk("R2 mode C", rd_c, 32'h0);
        access(1'b0, 8'h0C, 0);
        chk("R2 pull A", rd_a, 32'h6400_0000);
        chk("R2 pull B", rd_b, 32'h0000_0100);
        chk("R2 pull C", rd_c, 32'h0);
        access(1'b0, 8'h08, 0);
        chk("R2 speed A", rd_a, 32'h0);
        chk("R2 speed B", rd_b, 32'h0000_00C0);
        access(1'b0, 8'h14, 0);
        chk("R2 odr A", rd_a, 32'h0);
        access(1'b0, 8'h20, 0);
        chk("R2 afl B", rd_b, 32'h0);
        chk("R2 pins", {16'h0, po_a | po_b | po_c}, 32'h0);

        // R8 idle cycle after read gives zero
        idle(1);
        chk("R8 idle rdata", rd_a, 32'h0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v].wr, VECS[v].addr, VECS[v].data);
            chk($sformatf("R%0d row %0d rdata", VECS[v].req, v), rd_a, VECS[v].exp);
            chk($sformatf("R%0d row %0d err", VECS[v].req, v), {31'h0, err_a}, {31'h0, VECS[v].exp_err});
        end

        // R6 pin lines: pins 0,1 were driven up then down, rest held
        chk("R6 pins after table", {16'h0, po_a}, 32'h0);
        // pins 2,3 to output mode, bits already 1 but unchanged: line stays
        access(1'b1, 8'h00, 32'h0000_0050);
        chk("R6 enable without change", {16'h0, po_a}, 32'h0);
        access(1'b1, 8'h14, 32'h0000_0003);
        chk("R6 mode00 pins hold", {16'h0, po_a}, 32'h0);
        access(1'b1, 8'h14, 32'h0000_000F);
        chk("R6 driven pins follow", {16'h0, po_a}, 32'h0000_000C);

        // R7 input capture: pin 4 input with pull, pin 5 no pull
        @(negedge clk);
        pin_in = 16'h0030;
        idle(5);
        access(1'b0, 8'h10, 0);
        chk("R7 qualified capture", rd_a, 32'h0000_0010);
        // pin 4 to output mode, then its level drops: ignored
        access(1'b1, 8'h00, 32'h0000_0250);
        @(negedge clk);
        pin_in = 16'h0000;
        idle(5);
        access(1'b0, 8'h10, 0);
        chk("R7 output pin ignored", rd_a, 32'h0000_0010);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule